// File: doc/BRIEF.md
# Word-Select Oversampling Ratio Detector

This block finds out, with no configuration input, how many system-clock cycles fit into one period of the audio word-select signal. It then maps that count to one of six supported oversampling ratios: 128, 192, 256, 384, 512 and 768 times the sample rate. The system clock is supplied from outside and is assumed to be frequency-locked to word select. Word select arrives asynchronously and is brought into the system-clock domain first. A period is measured between two consecutive rising edges of the synchronised signal.

The detector reports a ratio only after several periods in a row agree on it. It raises an error flag when a period matches no permitted ratio, or when word select stops toggling. A low-sample-rate mode input removes the two smallest ratios from the permitted set. Downstream interpolation and noise-shaping logic use the reported ratio to pick their clock-enable pattern, and they hold off while the valid flag is low.

Top module: `ws_ratio_detect`

## Requirements
- R1: Word select passes through a two-flop synchroniser. A period is the number of system-clock cycles between two consecutive rising edges of the synchronised signal. The first rising edge after reset, and the first after a timeout, starts a measurement but produces none.
- R2: A period within ±TOL cycles (default 2) of a nominal ratio is classified with this code: 128→1, 192→2, 256→3, 384→4, 512→5, 768→6. Any other period is classified as code 0 (no match).
- R3: `ratio_code` carries the locked code while `ratio_valid` is high, and 0 while it is low.
- R4: While `low_rate_mode` is high at the measuring edge, periods near 128 or 192 are classified as code 0. Such periods raise the error flag and never produce a lock.
- R5: `ratio_valid` rises once LOCK_COUNT consecutive periods (default 3) have the same non-zero code. It falls on the first period whose code differs.
- R6: `ratio_err` rises on a period classified as code 0. It clears on the next period with a non-zero code.
- R7: If no synchronised rising edge occurs for TIMEOUT cycles (default 1024), counted from the last edge or from reset, `ratio_err` goes high and `ratio_valid` goes low.
- R8: While reset is held, and directly after it, `ratio_code` is 0, `ratio_valid` is 0 and `ratio_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every register of the block runs on it |
| rst_n | input | 1 | Active-low synchronous reset |
| ws_async | input | 1 | Word select, asynchronous to clk |
| low_rate_mode | input | 1 | High to forbid the 128 and 192 ratios |
| ratio_code | output | 3 | Locked ratio code (see R2), 0 when not valid |
| ratio_valid | output | 1 | High while a ratio is locked |
| ratio_err | output | 1 | High after an unclassifiable period or a word-select timeout |

## Verification
The bench targets the tolerance edges: 254 and 258 cycles must classify as 256, and 259 cycles must not. A design with an off-by-one window would lock on 259 or miss 258. It switches ratios while locked. This catches a detector that keeps its valid flag through a disagreeing period, and one that relocks with too few agreeing periods. It runs 128 and 192 periods with the low-rate mode set and expects an error with no lock; a missing mode gate would lock there. It stalls word select past the timeout and then restarts it. A design that never times out keeps a stale lock, and one that measures the restart edge against the stale count produces a spurious period.

// File: rtl/ws_ratio_pkg.sv
package ws_ratio_pkg;

   localparam int RATIO_COUNT = 6;
   localparam int CODE_W      = 3;
   localparam int LARGEST_NOM = 768;

   typedef logic [CODE_W-1:0] ratio_code_t;

   localparam ratio_code_t CODE_NONE = '0;

   // Nominal cycles per word-select period for slot idx; code is idx+1.
   function automatic int nominal(int idx);
      case (idx)
         0:       return 128;
         1:       return 192;
         2:       return 256;
         3:       return 384;
         4:       return 512;
         5:       return 768;
         default: return 0;
      endcase
   endfunction

   // Slots that remain permitted when the low-sample-rate mode is set.
   function automatic bit low_rate_ok(int idx);
      return idx >= 2;
   endfunction

endpackage

// File: rtl/ws_ratio_sync.sv
module ws_ratio_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ws_async,
   output logic rise_o
);

   // pipe[0..STAGES-1] synchronise; pipe[STAGES] is the edge-history flop.
   logic [STAGES:0] pipe;

   for (genvar g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) pipe[g] <= 1'b0;
            else        pipe[g] <= ws_async;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) pipe[g] <= 1'b0;
            else        pipe[g] <= pipe[g-1];
         end
      end
   end

   assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];

endmodule

// File: rtl/ws_ratio_period.sv
module ws_ratio_period #(
   parameter int TIMEOUT = 1024,
   parameter int CNT_W   = $clog2(TIMEOUT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise_i,
   output logic             meas_stb_o,
   output logic             tmo_stb_o,
   output logic [CNT_W-1:0] period_o
);

   localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(TIMEOUT);
   localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(TIMEOUT - 1);
   localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (rise_i) begin
         cnt_q   <= CNT_ONE;
         armed_q <= 1'b1;
      end else if (cnt_q == CNT_LAST) begin
         cnt_q   <= CNT_LIMIT;
         armed_q <= 1'b0;
      end else if (cnt_q != CNT_LIMIT) begin
         cnt_q   <= cnt_q + CNT_ONE;
      end
   end

   assign meas_stb_o = rise_i & armed_q;
   assign tmo_stb_o  = ~rise_i & (cnt_q == CNT_LAST);
   assign period_o   = cnt_q;

endmodule

// File: rtl/ws_ratio_classify.sv
module ws_ratio_classify
   import ws_ratio_pkg::*;
#(
   parameter int TOL   = 2,
   parameter int CNT_W = 11
) (
   input  logic [CNT_W-1:0] period_i,
   input  logic             low_rate_i,
   output ratio_code_t      code_o
);

   logic [RATIO_COUNT-1:0] hit;

   for (genvar g = 0; g < RATIO_COUNT; g++) begin : g_slot
      localparam int LO = nominal(g) - TOL;
      localparam int HI = nominal(g) + TOL;
      logic in_window;
      logic permitted;
      assign in_window = (32'(period_i) >= LO) && (32'(period_i) <= HI);
      assign permitted = low_rate_ok(g) || !low_rate_i;
      assign hit[g]    = in_window && permitted;
   end

   always_comb begin
      code_o = CODE_NONE;
      for (int i = 0; i < RATIO_COUNT; i++) begin
         if (hit[i]) code_o = CODE_W'(i + 1);
      end
   end

endmodule

// File: rtl/ws_ratio_lock.sv
module ws_ratio_lock
   import ws_ratio_pkg::*;
#(
   parameter int LOCK_COUNT = 3,
   parameter int RUN_W      = $clog2(LOCK_COUNT + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        meas_stb_i,
   input  logic        tmo_stb_i,
   input  ratio_code_t code_i,
   output ratio_code_t code_o,
   output logic        valid_o,
   output logic        err_o
);

   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(LOCK_COUNT);
   localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

   ratio_code_t      last_q;
   logic [RUN_W-1:0] run_q;
   logic             err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q <= CODE_NONE;
         run_q  <= '0;
         err_q  <= 1'b0;
      end else if (tmo_stb_i) begin
         last_q <= CODE_NONE;
         run_q  <= '0;
         err_q  <= 1'b1;
      end else if (meas_stb_i) begin
         last_q <= code_i;
         if (code_i == CODE_NONE) begin
            run_q <= '0;
            err_q <= 1'b1;
         end else begin
            err_q <= 1'b0;
            if (code_i == last_q && run_q != '0)
               run_q <= (run_q == RUN_MAX) ? RUN_MAX : run_q + RUN_ONE;
            else
               run_q <= RUN_ONE;
         end
      end
   end

   assign valid_o = (run_q == RUN_MAX);
   assign code_o  = valid_o ? last_q : CODE_NONE;
   assign err_o   = err_q;

endmodule

// File: rtl/ws_ratio_detect.sv
module ws_ratio_detect
   import ws_ratio_pkg::*;
#(
   parameter int TOL         = 2,
   parameter int TIMEOUT     = 1024,
   parameter int LOCK_COUNT  = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ws_async,
   input  logic              low_rate_mode,
   output logic [CODE_W-1:0] ratio_code,
   output logic              ratio_valid,
   output logic              ratio_err
);

   localparam int CNT_W = $clog2(TIMEOUT + 1);
   localparam int RUN_W = $clog2(LOCK_COUNT + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $fatal(1, "SYNC_STAGES must be at least 2");
   end
   if (TIMEOUT <= LARGEST_NOM + TOL) begin : g_bad_tmo
      $fatal(1, "TIMEOUT must exceed the largest nominal period plus TOL");
   end
   if (LOCK_COUNT < 1) begin : g_bad_lock
      $fatal(1, "LOCK_COUNT must be at least 1");
   end
   if (TOL < 0 || 2 * TOL >= 64) begin : g_bad_tol
      $fatal(1, "TOL must keep the ratio windows apart");
   end

   logic             ws_rise;
   logic             meas_stb;
   logic             tmo_stb;
   logic [CNT_W-1:0] period;
   ratio_code_t      period_code;
   ratio_code_t      locked_code;

   ws_ratio_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .ws_async (ws_async),
      .rise_o   (ws_rise)
   );

   ws_ratio_period #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_period (
      .clk        (clk),
      .rst_n      (rst_n),
      .rise_i     (ws_rise),
      .meas_stb_o (meas_stb),
      .tmo_stb_o  (tmo_stb),
      .period_o   (period)
   );

   ws_ratio_classify #(.TOL(TOL), .CNT_W(CNT_W)) u_class (
      .period_i   (period),
      .low_rate_i (low_rate_mode),
      .code_o     (period_code)
   );

   ws_ratio_lock #(.LOCK_COUNT(LOCK_COUNT), .RUN_W(RUN_W)) u_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .meas_stb_i (meas_stb),
      .tmo_stb_i  (tmo_stb),
      .code_i     (period_code),
      .code_o     (locked_code),
      .valid_o    (ratio_valid),
      .err_o      (ratio_err)
   );

   assign ratio_code = locked_code;

endmodule

// File: rtl/ws_ratio_checker.sv
module ws_ratio_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       ws_async,
   input logic       low_rate_mode,
   input logic [2:0] ratio_code,
   input logic       ratio_valid,
   input logic       ratio_err,
   input logic       meas_stb,
   input logic       tmo_stb
);

   // R1: a measurement needs word select high two samples earlier
   a_r1_edge_from_input: assert property (@(posedge clk) disable iff (!rst_n)
      meas_stb |-> $past(ws_async, 2));

   // R2: only defined codes appear
   a_r2_code_range: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_code <= 3'd6);

   // R3: code holds steady across a continuing lock
   a_r3_code_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_valid && $past(ratio_valid)) |-> $stable(ratio_code));

   // R4: a measurement in low-rate mode never leaves a 128 or 192 lock
   a_r4_low_rate_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_stb && low_rate_mode) |=> !(ratio_valid && ratio_code < 3'd3));

   // R5: lock is only gained on a measured period
   a_r5_lock_on_period: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ratio_valid) |-> $past(meas_stb));

   // R6: error only rises on a measurement or a timeout
   a_r6_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ratio_err) |-> $past(meas_stb || tmo_stb));

   // R7: timeout drops the lock and flags an error
   a_r7_timeout: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_stb |=> (ratio_err && !ratio_valid));

endmodule

bind ws_ratio_detect ws_ratio_checker u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ws_async      (ws_async),
   .low_rate_mode (low_rate_mode),
   .ratio_code    (ratio_code),
   .ratio_valid   (ratio_valid),
   .ratio_err     (ratio_err),
   .meas_stb      (meas_stb),
   .tmo_stb       (tmo_stb)
);

// File: tb/tb_ws_ratio_detect.sv
`timescale 1ns/1ps
module tb_ws_ratio_detect;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ws = 1'b0;
   logic       low = 1'b0;
   logic [2:0] ratio_code;
   logic       ratio_valid;
   logic       ratio_err;

   int checks = 0;
   int errors = 0;
   bit cmp_on = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ws_ratio_detect dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .ws_async      (ws),
      .low_rate_mode (low),
      .ratio_code    (ratio_code),
      .ratio_valid   (ratio_valid),
      .ratio_err     (ratio_err)
   );

   // Behavioural reference: sampled history queue plus integer counters.
   int hist[$] = '{0, 0, 0};
   int since = 0;
   bit primed = 0;
   int last_code = 0;
   int streak = 0;
   int exp_err = 0;

   function automatic int classify(int per, bit lowm);
      int noms[6] = '{128, 192, 256, 384, 512, 768};
      for (int i = 0; i < 6; i++) begin
         if (lowm && i < 2) continue;
         if (per >= noms[i] - 2 && per <= noms[i] + 2) return i + 1;
      end
      return 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         hist = '{0, 0, 0};
         since = 0; primed = 0; last_code = 0; streak = 0; exp_err = 0;
      end else begin
         bit edge_seen;
         edge_seen = (hist[1] == 1) && (hist[2] == 0);
         if (edge_seen && primed) begin
            int c;
            c = classify(since, low);
            if (c == 0) begin
               streak = 0; exp_err = 1;
            end else begin
               exp_err = 0;
               if (c == last_code && streak > 0) streak = (streak >= 3) ? 3 : streak + 1;
               else streak = 1;
            end
            last_code = c;
         end else if (!edge_seen && since == 1023) begin
            streak = 0; exp_err = 1; last_code = 0; primed = 0;
         end
         if (edge_seen) begin
            since = 1; primed = 1;
         end else if (since < 1024) begin
            since = since + 1;
         end
         hist.push_front(int'(ws));
         void'(hist.pop_back());
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on) begin
         int ev;
         ev = (streak >= 3) ? 1 : 0;
         chk("R5", "valid vs model", int'(ratio_valid), ev);
         chk("R3", "code vs model", int'(ratio_code), ev ? last_code : 0);
         chk("R6", "err vs model", int'(ratio_err), exp_err);
      end
   end

   task automatic run_periods(int p, int n);
      for (int k = 0; k < n; k++) begin
         ws = 1'b1;
         repeat (p / 2) @(negedge clk);
         ws = 1'b0;
         repeat (p - p / 2) @(negedge clk);
      end
   endtask

   task automatic expect_out(string req, int code, int valid, int err);
      chk(req, "ratio_code", int'(ratio_code), code);
      chk(req, "ratio_valid", int'(ratio_valid), valid);
      chk(req, "ratio_err", int'(ratio_err), err);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      expect_out("R8", 0, 0, 0);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      @(negedge clk);
      expect_out("R8", 0, 0, 0);

      run_periods(256, 6);
      expect_out("R2", 3, 1, 0);
      run_periods(384, 2);
      chk("R5", "valid after ratio change", int'(ratio_valid), 0);
      chk("R3", "code zero while unlocked", int'(ratio_code), 0);
      run_periods(384, 3);
      expect_out("R5", 4, 1, 0);

      low = 1'b1;
      run_periods(128, 5);
      expect_out("R4", 0, 0, 1);
      run_periods(192, 4);
      expect_out("R4", 0, 0, 1);
      low = 1'b0;
      run_periods(192, 5);
      expect_out("R6", 2, 1, 0);

      run_periods(258, 5);
      expect_out("R2", 3, 1, 0);
      run_periods(254, 5);
      expect_out("R2", 3, 1, 0);
      run_periods(259, 4);
      expect_out("R2", 0, 0, 1);
      run_periods(768, 5);
      expect_out("R2", 6, 1, 0);
      run_periods(512, 5);
      expect_out("R2", 5, 1, 0);
      run_periods(128, 5);
      expect_out("R2", 1, 1, 0);

      ws = 1'b0;
      repeat (1100) @(negedge clk);
      expect_out("R7", 0, 0, 1);
      run_periods(256, 2);
      chk("R1", "no lock from restart edge", int'(ratio_valid), 0);
      chk("R6", "err cleared by good period", int'(ratio_err), 0);
      run_periods(256, 3);
      expect_out("R1", 3, 1, 0);

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL WATCHDOG all requirements: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule